// File: doc/BRIEF.md
# Register-Driven SPI Byte Master

This block lets a processor talk to an external serial flash one byte at a time, through a small set of bus registers. Software owns the chip-select line outright. It pulls the line low through an enable register and keeps it low for as long as a command lasts. It then moves bytes one by one. For each byte it loads the data register, writes the transfer register to start the shift, polls the transfer register until it reads ready, and reads the data register to collect the byte that came back from the slave.

The shift engine runs SPI mode 0. The serial clock idles low. The incoming line is sampled on each rising edge. The outgoing line changes on each falling edge. Bits go out most significant first. The serial clock is the system clock divided by an even parameter. A byte takes exactly eight serial clock periods, and no clock pulses are produced outside a transfer. Flash command sequencing and multi-byte bursts are left to software.

Top module: `spi_byte_master`

## Requirements
- R1: After reset, chip select (`spi_csn`) is high, `spi_sclk` is low, a read of the transfer register (offset 0x81) returns a nonzero value, and a read of the data register (offset 0x82) returns zero.
- R2: A write to the enable register (offset 0x80) with bit 0 set drives `spi_csn` low from the next cycle. A write with bit 0 clear drives it high. Reading the enable register returns the stored bit in bit 0 and zero in all other bits.
- R3: Any write to the transfer register while the master is ready starts one byte transfer. From the following cycle the transfer register reads zero until the transfer ends.
- R4: A transfer keeps the master busy for exactly 8 × CLK_DIV system cycles, and produces exactly eight rising edges of `spi_sclk`, whose period is CLK_DIV system cycles.
- R5: Only bits [7:0] of the last value written to the data register are shifted out, most significant bit first. `spi_mosi` holds steady while `spi_sclk` is high.
- R6: After a transfer completes, reading the data register returns the eight `spi_miso` values sampled on the rising edges, first sample in bit 7, zero-extended to the bus width.
- R7: `spi_sclk` is low whenever no transfer is in progress.
- R8: A write to the transfer register while a transfer is in progress is ignored. The running transfer neither restarts nor lengthens, and no second transfer follows it.
- R9: Reading any offset other than the three register offsets returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register offset for reads and writes |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_csn | output | 1 | Chip select, active low, set by software |
| spi_mosi | output | 1 | Serial data to the slave |
| spi_miso | input | 1 | Serial data from the slave |

## Verification
The bench builds the block with CLK_DIV = 4, so every transfer is 32 cycles long. This makes it affordable to sweep all 256 transmit byte values, each paired with a different slave reply computed arithmetically. Every transfer checks the exact busy length, the rising-edge count, the byte seen on the serial output and the byte read back. One transfer in four also receives a second start write while it is busy, to show that the write is ignored. Junk in the upper write-data bits, toggling chip select, and reads of unmapped offsets cover the remaining register behaviour.

// File: rtl/spi_bm_pkg.sv
// Package: shared constants for the SPI byte master.
// Assumes an 8-bit serial frame and default register offsets that the
// top module may override through parameters.
package spi_bm_pkg;
    localparam int BYTE_W          = 8;
    localparam int DEF_ADDR_W      = 8;
    localparam int DEF_DATA_W      = 32;
    localparam logic [7:0] OFS_EN  = 8'h80;
    localparam logic [7:0] OFS_GO  = 8'h81;
    localparam logic [7:0] OFS_BUF = 8'h82;
endpackage

// File: rtl/spi_bm_clkgen.sv
// Module: serial clock generator.
// While run is high it toggles sclk every CLK_DIV/2 system cycles and
// flags the cycle before each toggle as a rising or a falling step.
// Assumes CLK_DIV is even and at least 2. When run is low, sclk is held low.
module spi_bm_clkgen #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic step_rise,
    output logic step_fall
);
    localparam int HALF = CLK_DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt;
    logic          tick;

    // flag the last cycle of each half period
    assign tick      = run && (cnt == CW'(HALF - 1));
    assign step_rise = tick && !sclk;
    assign step_fall = tick && sclk;

    // half-period counter and clock toggle
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else if (tick) begin
            cnt  <= '0;
            sclk <= ~sclk;
        end else begin
            cnt  <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/spi_bm_shifter.sv
// Module: mode-0 byte shift engine.
// A start pulse is taken only while idle. It loads the byte and holds busy
// until the eighth falling step. The input is sampled on rising steps and
// the output advances on falling steps, MSB first. The received byte is
// latched when the transfer ends.
module spi_bm_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              step_rise,
    input  logic              step_fall,
    input  logic              miso,
    output logic              busy,
    output logic              mosi,
    output logic [BYTE_W-1:0] rx_byte
);
    localparam int BW = $clog2(BYTE_W);

    logic [BYTE_W-1:0] tx_sh;
    logic [BYTE_W-1:0] rx_sh;
    logic [BW-1:0]     nfall;
    logic              last_fall;

    assign last_fall = step_fall && (nfall == BW'(BYTE_W - 1));
    assign mosi      = busy ? tx_sh[BYTE_W-1] : 1'b0;

    // transfer control: accept start when idle, stop on the final falling step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            nfall <= '0;
        end else if (!busy) begin
            busy  <= start;
            nfall <= '0;
        end else if (step_fall) begin
            nfall <= nfall + 1'b1;
            if (last_fall) busy <= 1'b0;
        end
    end

    // data path: load, shift out, sample in, latch the result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh   <= '0;
            rx_sh   <= '0;
            rx_byte <= '0;
        end else if (!busy) begin
            if (start) tx_sh <= tx_byte;
        end else begin
            if (step_rise) rx_sh <= {rx_sh[BYTE_W-2:0], miso};
            if (step_fall) tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
            if (last_fall) rx_byte <= rx_sh;
        end
    end
endmodule

// File: rtl/spi_bm_regs.sv
// Module: bus register file for the SPI byte master.
// It holds the chip-select enable bit and the transmit byte, decodes start
// writes, and muxes read data combinationally. Assumes DATA_W > BYTE_W.
// Only the low byte of the write data reaches the transmit register.
module spi_bm_regs #(
    parameter int              ADDR_W = 8,
    parameter int              DATA_W = 32,
    parameter int              BYTE_W = 8,
    parameter logic [ADDR_W-1:0] A_EN  = 8'h80,
    parameter logic [ADDR_W-1:0] A_GO  = 8'h81,
    parameter logic [ADDR_W-1:0] A_BUF = 8'h82
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              busy,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              cs_en,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              start
);
    logic unused_wbits;
    assign unused_wbits = ^bus_wdata[DATA_W-1:BYTE_W];

    // a start request is any write to the transfer offset
    assign start = bus_we && (bus_addr == A_GO);

    // writable registers: chip-select enable and transmit byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_en   <= 1'b0;
            tx_byte <= '0;
        end else if (bus_we) begin
            if (bus_addr == A_EN)  cs_en   <= bus_wdata[0];
            if (bus_addr == A_BUF) tx_byte <= bus_wdata[BYTE_W-1:0];
        end
    end

    // read mux: enable bit, ready flag, received byte, zero elsewhere
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_EN)       bus_rdata[0] = cs_en;
        else if (bus_addr == A_GO)  bus_rdata[0] = !busy;
        else if (bus_addr == A_BUF) bus_rdata[BYTE_W-1:0] = rx_byte;
    end
endmodule

// File: rtl/spi_byte_master.sv
// Module: register-driven SPI byte master (top).
// Software sets chip select, loads a byte, starts a transfer, polls for
// ready and reads the received byte. Mode 0, MSB first, with the serial
// clock at clk / CLK_DIV. Assumes CLK_DIV is even and at least 2.
module spi_byte_master
    import spi_bm_pkg::*;
#(
    parameter int                ADDR_W  = DEF_ADDR_W,
    parameter int                DATA_W  = DEF_DATA_W,
    parameter int                CLK_DIV = 4,
    parameter logic [ADDR_W-1:0] A_EN    = ADDR_W'(OFS_EN),
    parameter logic [ADDR_W-1:0] A_GO    = ADDR_W'(OFS_GO),
    parameter logic [ADDR_W-1:0] A_BUF   = ADDR_W'(OFS_BUF)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              spi_sclk,
    output logic              spi_csn,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    logic              busy;
    logic              cs_en;
    logic              start;
    logic              step_rise;
    logic              step_fall;
    logic [BYTE_W-1:0] tx_byte;
    logic [BYTE_W-1:0] rx_byte;

    assign spi_csn = !cs_en;

    spi_bm_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W),
        .A_EN(A_EN), .A_GO(A_GO), .A_BUF(A_BUF)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .busy(busy), .rx_byte(rx_byte),
        .cs_en(cs_en), .tx_byte(tx_byte), .start(start)
    );

    spi_bm_clkgen #(.CLK_DIV(CLK_DIV)) u_clk (
        .clk(clk), .rst_n(rst_n), .run(busy),
        .sclk(spi_sclk), .step_rise(step_rise), .step_fall(step_fall)
    );

    spi_bm_shifter #(.BYTE_W(BYTE_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_byte(tx_byte),
        .step_rise(step_rise), .step_fall(step_fall), .miso(spi_miso),
        .busy(busy), .mosi(spi_mosi), .rx_byte(rx_byte)
    );
endmodule

// File: rtl/spi_bm_chk.sv
// Module: protocol checker for the SPI byte master, bound to the top.
// It observes the ports and the internal busy flag. A cycle counter checks
// the transfer length so that no long delay has to be unrolled.
module spi_bm_chk #(
    parameter int                ADDR_W  = 8,
    parameter int                DATA_W  = 32,
    parameter int                CLK_DIV = 4,
    parameter logic [ADDR_W-1:0] A_EN    = 8'h80,
    parameter logic [ADDR_W-1:0] A_GO    = 8'h81
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              spi_sclk,
    input logic              spi_csn,
    input logic              spi_mosi,
    input logic              busy
);
    localparam int TOTAL = 8 * CLK_DIV;
    localparam int TW    = $clog2(TOTAL + 1);

    logic [TW-1:0] bcnt;

    // cycles spent busy in the current transfer
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) bcnt <= '0;
        else                 bcnt <= bcnt + 1'b1;
    end

    // R2
    cs_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_EN) |=> (spi_csn == !$past(bus_wdata[0])));

    // R3
    start_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_GO && !busy) |=> busy);

    // R4
    busy_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (bcnt < TW'(TOTAL)));

    // R4
    busy_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(bcnt) == TW'(TOTAL - 1)));

    // R5
    mosi_steady_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

    // R7
    sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !spi_sclk);

    // R8
    only_idle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(bus_we && bus_addr == A_GO));
endmodule

bind spi_byte_master spi_bm_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLK_DIV(CLK_DIV),
    .A_EN(A_EN), .A_GO(A_GO)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .spi_sclk(spi_sclk), .spi_csn(spi_csn),
    .spi_mosi(spi_mosi), .busy(busy)
);

// File: tb/tb_spi_byte_master.sv
// Bench: sweeps all transmit bytes against a mode-0 slave model.
module tb_spi_byte_master;
    localparam int CLK_DIV = 4;
    localparam int TOTAL   = 8 * CLK_DIV;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        spi_sclk, spi_csn, spi_mosi;
    logic        spi_miso;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    spi_byte_master #(.CLK_DIV(CLK_DIV)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sclk(spi_sclk),
        .spi_csn(spi_csn), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    // slave model: mode 0, shifts out on falling, captures on rising
    logic [7:0] sl_out = 8'h00;
    logic [7:0] sl_cap = 8'h00;
    int         n_rise = 0;
    assign spi_miso = sl_out[7];

    always @(negedge spi_sclk) sl_out <= {sl_out[6:0], 1'b0};
    always @(posedge spi_sclk) begin
        sl_cap <= {sl_cap[6:0], spi_mosi};
        n_rise <= n_rise + 1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // one full transfer with optional start write while busy
    task automatic xfer(input logic [31:0] wd, input logic [7:0] reply, input bit dup);
        logic [31:0] v;
        int zeros;
        wr(8'h82, wd);
        sl_out = reply;
        n_rise = 0;
        wr(8'h81, 32'h0);
        bus_addr = 8'h81;
        zeros = 0;
        #1;
        while (bus_rdata == 0 && zeros < 4 * TOTAL) begin
            zeros++;
            @(negedge clk);
            bus_we = (dup && zeros == 5);
            bus_addr = 8'h81;
            #1;
        end
        bus_we = 1'b0;
        repeat (3 * CLK_DIV) @(negedge clk);
        check(zeros == TOTAL, dup ? "R8" : "R4", "busy cycles", zeros, TOTAL);
        check(n_rise == 8, dup ? "R8" : "R4", "rising edges", n_rise, 8);
        check(sl_cap == wd[7:0], "R5", "byte on mosi", sl_cap, wd[7:0]);
        check(spi_sclk == 1'b0, "R7", "sclk idle", spi_sclk, 0);
        rd(8'h82, v);
        check(v == {24'h0, reply}, "R6", "received byte", v, reply);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check(spi_csn == 1'b1, "R1", "csn after reset", spi_csn, 1);
        check(spi_sclk == 1'b0, "R1", "sclk after reset", spi_sclk, 0);
        rd(8'h81, v);
        check(v != 0, "R1", "ready after reset", v, 1);
        rd(8'h82, v);
        check(v == 0, "R1", "data after reset", v, 0);
        // R9 unmapped offsets
        for (int a = 0; a < 256; a++) begin
            if (a >= 8'h80 && a <= 8'h82) continue;
            rd(8'(a), v);
            check(v == 0, "R9", "unmapped read", v, 0);
        end
        // R2 chip select control
        wr(8'h80, 32'hFFFF_FF01);
        check(spi_csn == 1'b0, "R2", "csn after enable", spi_csn, 0);
        rd(8'h80, v);
        check(v == 32'h1, "R2", "enable readback", v, 1);
        wr(8'h80, 32'hFFFF_FFFE);
        check(spi_csn == 1'b1, "R2", "csn after disable", spi_csn, 1);
        rd(8'h80, v);
        check(v == 32'h0, "R2", "disable readback", v, 0);
        wr(8'h80, 32'h1);
        // R3 start then busy
        wr(8'h82, 32'h5A);
        sl_out = 8'hC3;
        n_rise = 0;
        wr(8'h81, 32'h0);
        #1 check(bus_rdata == 0 || bus_addr != 8'h81, "R3", "busy after start", 1, 0);
        rd(8'h81, v);
        check(v == 0, "R3", "transfer reg reads busy", v, 0);
        repeat (TOTAL + 4) @(negedge clk);
        rd(8'h81, v);
        check(v != 0, "R3", "ready after transfer", v, 1);
        // exhaustive sweep of transmit bytes, R4 R5 R6 R7 R8
        for (int t = 0; t < 256; t++) begin
            logic [7:0] reply;
            reply = 8'((t * 37 + 11) & 8'hFF);
            xfer({8'hA5, 8'h3C, 8'(t ^ 8'h96), 8'(t)}, reply, (t % 4) == 1);
            check(spi_csn == 1'b0, "R2", "csn held low across transfers", spi_csn, 0);
        end
        wr(8'h80, 32'h0);
        check(spi_csn == 1'b1, "R2", "csn released", spi_csn, 1);
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule